// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Request Logic

This block gathers three event sources of a real-time clock: the end of a time update, an alarm match and a periodic tick. Each arrives as a one-cycle pulse. The block latches each pulse into its own sticky flag. It then combines the flags with per-source enable bits to drive one active-high interrupt request. Software reaches the block through a small register port. It has a control register that holds the three enables, a status register that reports the flags together with a summary request bit, and a second status register that reports whether the RAM and time contents are valid.

A flag latches whether or not its enable is set. Only the request output, and the summary bit that mirrors it, depend on the enables. A single read of the flag status register returns the current value and clears every flag on the next clock edge. An event that arrives during that same read survives the clear. This way a handler that reads status and then returns does not lose an event.

Top module: `irqf_top`

## Requirements
- R1: After a synchronous active-low reset, all three flags and all three enables are 0, `irq_o` is 0, and reads of addresses 0xB and 0xC return 0x00.
- R2: A pulse on an event input sets its flag on the next clock edge, whether or not its enable is set. The flag then reads back in register 0xC: update at bit 4, alarm at bit 5, periodic at bit 6.
- R3: Bits 3:0 of register 0xC always read as 0.
- R4: `irq_o` and bit 7 of register 0xC both equal the OR over the three sources of (flag AND enable).
- R5: A read of address 0xC (`reg_rd_i` high) returns the current value. On the following edge it clears all flags, so `irq_o` is 0 in the next cycle unless a new event arrived.
- R6: An event pulse in the same cycle as a clearing read leaves its flag set after that edge.
- R7: Writing a 1 to an enable bit while its flag is latched drives `irq_o` high from the cycle right after the write edge.
- R8: Register 0xB holds the enables at bit 4 (update), bit 5 (alarm) and bit 6 (periodic). Its other bits ignore writes and read as 0.
- R9: Register 0xD reads `ram_valid_i` at bit 7 and 0 in bits 6:0. Any address other than 0xB, 0xC and 0xD reads 0x00.
- R10: Writes to 0xC and 0xD have no effect on the flags, the enables or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_update_i | input | 1 | One-cycle pulse: time update ended |
| evt_alarm_i | input | 1 | One-cycle pulse: alarm matched |
| evt_periodic_i | input | 1 | One-cycle pulse: periodic tick |
| ram_valid_i | input | 1 | RAM and time contents are valid |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_rd_i | input | 1 | Read strobe; a read of 0xC clears the flags |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address (combinational) |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
A flag that is stuck or lost shows at the ports in the cycle after the event pulse. It appears as a wrong bit 4, 5 or 6 in register 0xC, and as a wrong `irq_o` once that source is enabled. A corrupted enable shows as a wrong readback of 0xB, or as an `irq_o` that disagrees with the reported flags, on the next edge. A clear that misses, or one that swallows a coincident event, appears one cycle after the status read. The random stress mixes all of these, so each kind of error reaches the outputs within a cycle of the stimulus that exposes it.

// File: rtl/irqf_pkg.sv
// Package: shared register addresses and bit positions for the interrupt
// flag block. Assumes an 8-bit register data path.
package irqf_pkg;
    localparam int NSRC      = 3;          // update, alarm, periodic
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int SRC_LSB   = 4;          // flags and enables start here
    localparam int SUM_BIT   = 7;          // summary request bit in status
    localparam int VLD_BIT   = 7;          // valid bit in second status
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_STAT = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_VLD  = 4'hD;
    // source index order inside vectors
    typedef enum logic [1:0] {SRC_UPD = 2'd0, SRC_ALM = 2'd1, SRC_PER = 2'd2} src_e;
endpackage

// File: rtl/irqf_flag_cell.sv
// Module: one sticky event flag. Sets on its pulse, clears on a status
// read unless a new pulse arrives in the same cycle. Also forms the
// enabled request term. Assumes pulses last one cycle.
module irqf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic req_o
);
    logic flag_q;

    // Hold the flag: a new event has priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (evt_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    // Drive the request term for this source.
    always_comb begin
        flag_o = flag_q;
        req_o  = flag_q & en_i;
    end
endmodule

// File: rtl/irqf_regfile.sv
// Module: holds the enable bits and forms the read data for the control
// and status registers. Assumes DATA_W is at least SRC_LSB+NSRC and
// large enough for bit 7.
module irqf_regfile #(
    parameter int ADDR_W = irqf_pkg::ADDR_W,
    parameter int DATA_W = irqf_pkg::DATA_W,
    parameter int NSRC   = irqf_pkg::NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   flags_i,
    input  logic              sum_i,
    input  logic              vld_i,
    output logic [NSRC-1:0]   en_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    import irqf_pkg::*;
    localparam int SRC_MSB = SRC_LSB + NSRC - 1;

    logic [NSRC-1:0] en_q;

    // Capture enables on a write of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        en_q <= '0;
        else if (wr_i && addr_i == ADR_CTRL) en_q <= wdata_i[SRC_MSB:SRC_LSB];
    end

    // Decode the clearing read of the flag status register.
    always_comb clr_o = rd_i && (addr_i == ADR_STAT);

    // Select read data by address; unused bits stay zero.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADR_CTRL: rdata_o[SRC_MSB:SRC_LSB] = en_q;
            ADR_STAT: begin
                rdata_o[SRC_MSB:SRC_LSB] = flags_i;
                rdata_o[SUM_BIT]         = sum_i;
            end
            ADR_VLD:  rdata_o[VLD_BIT] = vld_i;
            default:  rdata_o = '0;
        endcase
    end

    // Export the enables.
    always_comb en_o = en_q;
endmodule

// File: rtl/irqf_top.sv
// Module: interrupt flag and request logic. Latches three event pulses,
// combines them with enables into one active-high request, and exposes
// control and status registers. Assumes single-cycle event pulses and
// a register master that holds address and strobes for one cycle.
module irqf_top #(
    parameter int ADDR_W = irqf_pkg::ADDR_W,
    parameter int DATA_W = irqf_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_update_i,
    input  logic              evt_alarm_i,
    input  logic              evt_periodic_i,
    input  logic              ram_valid_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    import irqf_pkg::*;

    logic [NSRC-1:0] evt_vec;
    logic [NSRC-1:0] flag_vec;
    logic [NSRC-1:0] req_vec;
    logic [NSRC-1:0] en_vec;
    logic            clr;
    logic            sum_req;

    // Gather the event inputs in source order.
    always_comb begin
        evt_vec[SRC_UPD] = evt_update_i;
        evt_vec[SRC_ALM] = evt_alarm_i;
        evt_vec[SRC_PER] = evt_periodic_i;
    end

    // One flag cell per source.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irqf_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_vec[i]),
            .clr_i  (clr),
            .en_i   (en_vec[i]),
            .flag_o (flag_vec[i]),
            .req_o  (req_vec[i])
        );
    end

    // Summary request from the enabled terms.
    always_comb sum_req = |req_vec;

    irqf_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .wdata_i (reg_wdata_i),
        .flags_i (flag_vec),
        .sum_i   (sum_req),
        .vld_i   (ram_valid_i),
        .en_o    (en_vec),
        .clr_o   (clr),
        .rdata_o (reg_rdata_o)
    );

    // Drive the interrupt output.
    always_comb irq_o = sum_req;
endmodule

// File: rtl/irqf_chk.sv
// Module: assertion checker for irqf_top, attached by bind.
module irqf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] evt_vec,
    input logic [2:0] flag_vec,
    input logic [3:0] reg_addr_i,
    input logic       reg_rd_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       irq_o
);
    // R2
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != 3'b000) |=> ((flag_vec & $past(evt_vec)) == $past(evt_vec)));
    // R3
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 4'hC) |-> (reg_rdata_o[3:0] == 4'h0));
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == 4'hC && evt_vec == 3'b000) |=> (!irq_o && flag_vec == 3'b000));
    // R6
    keep_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == 4'hC && evt_vec[1]) |=> flag_vec[1]);
    // R7
    en_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 4'hB && reg_wdata_i[4] && flag_vec[0]
         && !(reg_rd_i && reg_addr_i == 4'hC)) |=> irq_o);
    // R4
    sum_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 4'hC) |-> (reg_rdata_o[7] == irq_o));
endmodule

bind irqf_top irqf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_vec     (evt_vec),
    .flag_vec    (flag_vec),
    .reg_addr_i  (reg_addr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/irqf_top_tb.sv
module irqf_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e_upd = 0, e_alm = 0, e_per = 0, vld = 0;
    logic [3:0] addr = 0;
    logic       wr = 0, rd = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq;
    int checks = 0;
    int fails  = 0;
    bit done = 0;
    // bench model state
    logic [2:0] m_flag = 0;
    logic [2:0] m_en = 0;

    always #2.5 clk = ~clk;

    irqf_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_update_i(e_upd), .evt_alarm_i(e_alm),
        .evt_periodic_i(e_per), .ram_valid_i(vld), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic m_irq();
        return |(m_flag & m_en);
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'hB:    return {1'b0, m_en, 4'h0};
            4'hC:    return {m_irq(), m_flag, 4'h0};
            4'hD:    return {vld, 7'h0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare, update model at the rising edge.
    task automatic step(input logic [2:0] ev, input logic w, input logic r,
                        input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        {e_per, e_alm, e_upd} = ev;
        wr = w; rd = r; addr = a; wdata = d;
        #1;
        chk("R4 irq", {7'h0, irq}, {7'h0, m_irq()});
        if (a == 4'hB)      chk("R8 ctrl read", rdata, m_read(a));
        else if (a == 4'hC) chk("R2/R3 status read", rdata, m_read(a));
        else                chk("R9 read", rdata, m_read(a));
        @(posedge clk);
        if (r && a == 4'hC) m_flag = ev;
        else                m_flag = m_flag | ev;
        if (w && a == 4'hB) m_en = d[6:4];
    endtask

    // Look at an address with no strobes and compare against a fixed value.
    task automatic peek(input string tag, input logic [3:0] a, input logic [7:0] exp, input logic exp_irq);
        @(negedge clk);
        {e_per, e_alm, e_upd} = 3'b000;
        wr = 0; rd = 0; addr = a; wdata = 0;
        #1;
        chk(tag, rdata, exp);
        chk(tag, {7'h0, irq}, {7'h0, exp_irq});
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        peek("R1 status", 4'hC, 8'h00, 0);
        peek("R1 ctrl", 4'hB, 8'h00, 0);
        // R2 latch while disabled
        step(3'b001, 0, 0, 4'h0, 0);
        peek("R2 update flag disabled", 4'hC, 8'h10, 0);
        // R7 enable with latched flag
        step(3'b000, 1, 0, 4'hB, 8'hFF);
        peek("R7 irq on enable", 4'hC, 8'h90, 1);
        peek("R8 ctrl masks", 4'hB, 8'h70, 1);
        // R10 writes to status registers ignored
        step(3'b000, 1, 0, 4'hC, 8'h00);
        step(3'b000, 1, 0, 4'hD, 8'h00);
        peek("R10 status kept", 4'hC, 8'h90, 1);
        peek("R10 ctrl kept", 4'hB, 8'h70, 1);
        // R5 clearing read
        step(3'b000, 0, 1, 4'hC, 0);
        peek("R5 cleared", 4'hC, 8'h00, 0);
        // R6 event coincident with clear
        step(3'b110, 0, 0, 4'h0, 0);
        step(3'b010, 0, 1, 4'hC, 0);
        peek("R6 alarm kept", 4'hC, 8'hA0, 1);
        // R9 valid bit
        vld = 1;
        peek("R9 valid set", 4'hD, 8'h80, 1);
        peek("R9 other addr", 4'h3, 8'h00, 1);
        vld = 0;
        peek("R9 valid clear", 4'hD, 8'h00, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ev;
            logic w, r;
            logic [3:0] a;
            ev = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            w  = (($urandom % 6) == 0);
            r  = (($urandom % 5) == 0);
            a  = (($urandom % 4) == 0) ? 4'($urandom) : (4'hB + 4'($urandom % 3));
            vld = 1'($urandom);
            step(ev, w, r, a, 8'($urandom));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule